// File: doc/BRIEF.md
# Serially Configured Output Selector

This block is a two-wire serial slave, answering one fixed 7-bit address, that holds a small configuration register of five bits. The low four bits feed a two-way selector, and a select pin chooses between those bits and a four-bit external input. The fifth bit drives a single output through a latch. The latch follows the register while the select pin is low and freezes when the select pin goes high. An active-low override pin forces every output to zero, but only while the register side of the selector is chosen.

Software writes and reads the register with single-byte transfers. A write is refused when the write-protect pin is high, when the power-good input is low, or when any of the three upper data bits is set. The register is built from flip-flops and clears on reset. The serial lines are sampled through synchronisers on the system clock. The data line is driven open-drain through an output-enable that pulls the line low.

Top module: `i2c_cfg_selector`

## Requirements
- R1: Only address byte 1001110 followed by a R/W bit (R/W=0 write, R/W=1 read) is acknowledged (SDA held low in the ninth clock). Any other address gets no acknowledge, and the data that follows leaves the register unchanged.
- R2: A write of one data byte with bits 7:5 all zero is acknowledged and is stored on the STOP that follows it. Bit 4 goes to the latched bit and bits 3:0 go to the selector nibble. The stored value shows at the ports and in later reads.
- R3: A write data byte with any of bits 7:5 set is not acknowledged and does not change the register.
- R4: When the write-protect input is 1 or the power-good input is 0, a valid write is still acknowledged but the register keeps its previous contents.
- R5: A read transfers one byte, MSB first, equal to {3'b000, register[4:0]}. The slave then releases SDA and returns to idle.
- R6: After reset the register is zero, so with select at 0 the selector output and the latched output are both 0, and a read returns 8'h00.
- R7: With select at 0 and override at 1, the 4-bit output equals register bits 3:0. With select at 1 it equals the external input, whatever the override level.
- R8: While select is 0 the latched output follows the value driven for register bit 4. When select rises, it keeps the value driven at the last clock edge before the rise and stays unchanged while select is 1, even if the register is rewritten.
- R9: With override at 0 and select at 0, the 4-bit output and the latched output are both 0. If select then rises with override still at 0, the latched output holds that 0 and the external input passes.
- R10: A repeated START restarts the address phase. A data byte that is followed by a repeated START instead of a STOP is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | When 1, pull the data line low |
| selPin | input | 1 | 0 selects the register nibble, 1 selects the external input |
| overrideN | input | 1 | Active-low force-to-zero on the register path |
| wrProtect | input | 1 | 1 blocks register writes |
| powerGood | input | 1 | 0 blocks register writes |
| extIn | input | 4 | External data for the selector |
| selOut | output | 4 | Selected nibble |
| heldOut | output | 1 | Latched copy of register bit 4 |

## Verification
A wrong stored register value shows at the selector output in the same cycle whenever select is 0 and override is 1, and it shows in the byte returned by the next read. A latch that captures on the wrong edge, or that is not gated, shows as a change on the latched output while select is high. That change comes within one clock of a register write or an override toggle. A control state that fails to track the serial framing shows within the same byte, as a missing or extra acknowledge in the ninth clock or as a wrong read bit. A write that is wrongly committed or dropped shows on the selector output a few clocks after the STOP.

// File: rtl/cfg_sel_pkg.sv
package cfg_sel_pkg;

  // Strobes from the serial control to the datapath
  typedef struct packed {
    logic rxShift;   // shift the sampled data bit into the receive byte
    logic rxBit;     // synchronised data line level
    logic txLoad;    // load the read byte from the register
    logic txShift;   // advance the read byte by one bit
    logic commit;    // STOP after a valid write byte
  } strobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK_A,
    ST_WDATA,
    ST_WDATA_END,
    ST_ACK_D,
    ST_WPEND,
    ST_RDATA,
    ST_RACK
  } ctrl_state_t;

endpackage

// File: rtl/cfg_sel_ctrl.sv
module cfg_sel_ctrl
  import cfg_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 5,
  parameter logic [DATA_W-2:0] SLAVE_ADDR = 7'b1001110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  output strobe_t           strb,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam int PAD_W = DATA_W - CFG_W;

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;
  ctrl_state_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  wire startC = sclS & sclPrev & sdaPrev & ~sdaS;
  wire stopC  = sclS & sclPrev & ~sdaPrev & sdaS;
  wire sclRise = sclS & ~sclPrev;
  wire sclFall = ~sclS & sclPrev;
  wire addrHit = (rxByte[DATA_W-1:1] == SLAVE_ADDR);
  wire byteOk  = (rxByte[DATA_W-1:CFG_W] == {PAD_W{1'b0}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      state   <= ST_IDLE;
      bitCnt  <= '0;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      state   <= stateNxt;
      bitCnt  <= bitCntNxt;
    end
  end

  always_comb begin
    strb = '0;
    strb.rxBit = sdaS;
    stateNxt = state;
    bitCntNxt = bitCnt;
    if (startC) begin
      stateNxt = ST_ADDR;
      bitCntNxt = '0;
    end else if (stopC) begin
      strb.commit = (state == ST_WPEND);
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_WDATA: if (sclRise) begin
          strb.rxShift = 1'b1;
          bitCntNxt = bitCnt + 1'b1;
          if (bitCnt == LAST_BIT)
            stateNxt = (state == ST_ADDR) ? ST_ADDR_END : ST_WDATA_END;
        end
        ST_ADDR_END: if (sclFall) stateNxt = addrHit ? ST_ACK_A : ST_IDLE;
        ST_ACK_A: if (sclFall) begin
          bitCntNxt = '0;
          if (rxByte[0]) begin
            stateNxt = ST_RDATA;
            strb.txLoad = 1'b1;
          end else begin
            stateNxt = ST_WDATA;
          end
        end
        ST_WDATA_END: if (sclFall) stateNxt = byteOk ? ST_ACK_D : ST_IDLE;
        ST_ACK_D: if (sclFall) stateNxt = ST_WPEND;
        ST_WPEND: if (sclFall) stateNxt = ST_IDLE;
        ST_RDATA: if (sclFall) begin
          strb.txShift = 1'b1;
          bitCntNxt = bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) stateNxt = ST_RACK;
        end
        ST_RACK: if (sclRise) stateNxt = ST_IDLE;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  assign sdaOe = (state == ST_ACK_A) || (state == ST_ACK_D) ||
                 ((state == ST_RDATA) && !txBit);

endmodule

// File: rtl/cfg_sel_dp.sv
module cfg_sel_dp
  import cfg_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              wrProtect,
  input  logic              powerGood,
  input  logic              selPin,
  input  logic              overrideN,
  input  logic [CFG_W-2:0]  extIn,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit,
  output logic [CFG_W-1:0]  cfgVal,
  output logic [CFG_W-2:0]  selOut,
  output logic              heldOut
);

  localparam int SEL_W = CFG_W - 1;
  localparam int PAD_W = DATA_W - CFG_W;

  logic [DATA_W-1:0] rxReg, txReg;
  logic [CFG_W-1:0]  cfgReg;
  logic              heldReg;
  logic              drivenBit;
  logic              writeEn;

  assign writeEn   = strb.commit & ~wrProtect & powerGood;
  assign drivenBit = cfgReg[SEL_W] & overrideN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '0;
      cfgReg  <= '0;
      heldReg <= 1'b0;
    end else begin
      if (strb.rxShift) rxReg <= {rxReg[DATA_W-2:0], strb.rxBit};
      if (strb.txLoad)       txReg <= {{PAD_W{1'b0}}, cfgReg};
      else if (strb.txShift) txReg <= {txReg[DATA_W-2:0], 1'b1};
      if (writeEn) cfgReg <= rxReg[CFG_W-1:0];
      if (!selPin) heldReg <= drivenBit;
    end
  end

  for (genvar g = 0; g < SEL_W; g++) begin : g_sel
    assign selOut[g] = selPin ? extIn[g] : (cfgReg[g] & overrideN);
  end

  assign heldOut = selPin ? heldReg : drivenBit;
  assign rxByte  = rxReg;
  assign txBit   = txReg[DATA_W-1];
  assign cfgVal  = cfgReg;

endmodule

// File: rtl/i2c_cfg_selector.sv
module i2c_cfg_selector
  import cfg_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 5,
  parameter logic [DATA_W-2:0] SLAVE_ADDR = 7'b1001110
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic             selPin,
  input  logic             overrideN,
  input  logic             wrProtect,
  input  logic             powerGood,
  input  logic [CFG_W-2:0] extIn,
  output logic [CFG_W-2:0] selOut,
  output logic             heldOut
);

  strobe_t           strb;
  logic [DATA_W-1:0] rxByte;
  logic              txBit;
  logic [CFG_W-1:0]  cfgVal;

  cfg_sel_ctrl #(.DATA_W(DATA_W), .CFG_W(CFG_W), .SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .sdaOe(sdaOe)
  );

  cfg_sel_dp #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrProtect(wrProtect),
    .powerGood(powerGood), .selPin(selPin), .overrideN(overrideN),
    .extIn(extIn), .rxByte(rxByte), .txBit(txBit), .cfgVal(cfgVal),
    .selOut(selOut), .heldOut(heldOut)
  );

endmodule

// File: rtl/cfg_sel_check.sv
module cfg_sel_check #(
  parameter int CFG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             selPin,
  input logic             overrideN,
  input logic             wrProtect,
  input logic             powerGood,
  input logic [CFG_W-2:0] extIn,
  input logic [CFG_W-2:0] selOut,
  input logic             heldOut,
  input logic [CFG_W-1:0] cfgVal
);

  assert_reg_path_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!selPin && overrideN) |-> (selOut == cfgVal[CFG_W-2:0]));

  assert_ext_path_R7: assert property (@(posedge clk) disable iff (!rstN)
    selPin |-> (selOut == extIn));

  assert_override_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!overrideN && !selPin) |-> (selOut == '0 && !heldOut));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (selPin && $past(selPin)) |-> $stable(heldOut));

  assert_write_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgVal) |-> $past(!wrProtect && powerGood));

endmodule

bind i2c_cfg_selector cfg_sel_check #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .selPin(selPin), .overrideN(overrideN),
  .wrProtect(wrProtect), .powerGood(powerGood), .extIn(extIn),
  .selOut(selOut), .heldOut(heldOut), .cfgVal(cfgVal)
);

// File: tb/sim_i2c_cfg_selector.sv
module sim_i2c_cfg_selector;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WATCHDOG = 150000;
  localparam logic [6:0] ADDR = 7'b1001110;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe;
  logic selPin = 1'b0, overrideN = 1'b1, wrProtect = 1'b0, powerGood = 1'b1;
  logic [3:0] extIn = 4'h0;
  logic [3:0] selOut;
  logic heldOut;
  wire sdaBus = sdaM & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_selector u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .selPin(selPin), .overrideN(overrideN), .wrProtect(wrProtect),
    .powerGood(powerGood), .extIn(extIn), .selOut(selOut), .heldOut(heldOut)
  );

  // Behavioural reference
  logic [4:0] mCfg = 5'h0;
  logic mHeld = 1'b0;
  bit cmpOn = 1'b0;
  int checks = 0, fails = 0, clkChecks = 0, clkFails = 0;

  always @(posedge clk) begin
    if (!rstN) mHeld <= 1'b0;
    else if (!selPin) mHeld <= overrideN & mCfg[4];
  end

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      logic [3:0] eSel;
      logic eHeld;
      eSel  = selPin ? extIn : (overrideN ? mCfg[3:0] : 4'h0);
      eHeld = selPin ? mHeld : (overrideN & mCfg[4]);
      clkChecks++;
      if (selOut !== eSel || heldOut !== eHeld) begin
        clkFails++;
        $display("FAIL R7/R8/R9 per-clock: selOut=%h heldOut=%b expected %h %b",
                 selOut, heldOut, eSel, eHeld);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    b = sdaBus; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = (b == 1'b0);
  endtask

  // One-byte write; the model is updated from the requirements afterwards
  task automatic writeTxn(input logic [6:0] a, input logic [7:0] d,
                          output bit aAck, output bit dAck);
    cmpOn = 1'b0;
    i2cStart();
    sendByte({a, 1'b0}, aAck);
    sendByte(d, dAck);
    i2cStop();
    tick(6);
    if (a == ADDR && d[7:5] == 3'b000 && !wrProtect && powerGood) mCfg = d[4:0];
    cmpOn = 1'b1;
  endtask

  task automatic readTxn(output bit aAck, output logic [7:0] d);
    logic b;
    i2cStart();
    sendByte({ADDR, 1'b1}, aAck);
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      recvBit(b);
      d = {d[6:0], b};
    end
    sendBit(1'b1);
    i2cStop();
    tick(4);
  endtask

  task automatic readCheck(input logic [7:0] exp, input string req);
    bit aAck;
    logic [7:0] d;
    readTxn(aAck, d);
    check(aAck, {req, " read address ack"}, aAck, 1);
    check(d === exp, {req, " read data"}, d, exp);
    check(sdaOe === 1'b0, {req, " SDA released after read"}, sdaOe, 0);
  endtask

  task automatic runAll();
    bit aAck, dAck;
    logic [7:0] d;
    tick(5);
    rstN = 1'b1;
    tick(2);
    // R6: reset state
    check(selOut === 4'h0, "R6 selOut after reset", selOut, 0);
    check(heldOut === 1'b0, "R6 heldOut after reset", heldOut, 0);
    cmpOn = 1'b1;
    readCheck(8'h00, "R6");

    // R2: valid write
    writeTxn(ADDR, 8'h15, aAck, dAck);
    check(aAck, "R1 address ack", aAck, 1);
    check(dAck, "R2 data ack", dAck, 1);
    check(selOut === 4'h5, "R2 selOut after write", selOut, 5);
    check(heldOut === 1'b1, "R2 heldOut after write", heldOut, 1);
    readCheck(8'h15, "R5");

    // R7: external path
    extIn = 4'hA; selPin = 1'b1; tick(3);
    check(selOut === 4'hA, "R7 external input passes", selOut, 4'hA);
    extIn = 4'h3; tick(3);
    check(selOut === 4'h3, "R7 external input follows", selOut, 3);

    // R8: held while select high across a write
    writeTxn(ADDR, 8'h0C, aAck, dAck);
    check(heldOut === 1'b1, "R8 held bit frozen across write", heldOut, 1);
    selPin = 1'b0; tick(3);
    check(heldOut === 1'b0, "R8 transparent again", heldOut, 0);
    check(selOut === 4'hC, "R7 register nibble", selOut, 4'hC);

    // R1: wrong address
    writeTxn(7'b0100111, 8'h1F, aAck, dAck);
    check(!aAck, "R1 wrong address not acked", aAck, 0);
    check(selOut === 4'hC, "R1 register unchanged", selOut, 4'hC);

    // R3: upper bits set
    writeTxn(ADDR, 8'hA3, aAck, dAck);
    check(!dAck, "R3 bad data byte not acked", dAck, 0);
    readCheck(8'h0C, "R3");

    // R4: write protect and power-good
    wrProtect = 1'b1;
    writeTxn(ADDR, 8'h1B, aAck, dAck);
    check(dAck, "R4 protected byte acked", dAck, 1);
    check(selOut === 4'hC, "R4 write-protect blocks", selOut, 4'hC);
    wrProtect = 1'b0; powerGood = 1'b0;
    writeTxn(ADDR, 8'h1B, aAck, dAck);
    check(selOut === 4'hC, "R4 power-good low blocks", selOut, 4'hC);
    powerGood = 1'b1;
    readCheck(8'h0C, "R4");

    // R10: repeated START before STOP discards the byte
    cmpOn = 1'b0;
    i2cStart();
    sendByte({ADDR, 1'b0}, aAck);
    sendByte(8'h09, dAck);
    check(dAck, "R10 byte acked before restart", dAck, 1);
    readTxn(aAck, d);
    check(aAck, "R10 address acked after repeated START", aAck, 1);
    check(d === 8'h0C, "R10 uncommitted byte discarded", d, 8'h0C);
    cmpOn = 1'b1;
    readCheck(8'h0C, "R10");

    // R9: override
    writeTxn(ADDR, 8'h17, aAck, dAck);
    overrideN = 1'b0; tick(3);
    check(selOut === 4'h0, "R9 override zeroes nibble", selOut, 0);
    check(heldOut === 1'b0, "R9 override zeroes held bit", heldOut, 0);
    extIn = 4'h6; selPin = 1'b1; tick(3);
    check(selOut === 4'h6, "R9 external passes under override", selOut, 6);
    check(heldOut === 1'b0, "R9 held keeps forced zero", heldOut, 0);
    overrideN = 1'b1; tick(3);
    check(heldOut === 1'b0, "R8 held unchanged by override release", heldOut, 0);
    selPin = 1'b0; tick(3);
    check(heldOut === 1'b1, "R8 follows register bit 4", heldOut, 1);
    check(selOut === 4'h7, "R7 register nibble after override", selOut, 7);
    tick(10);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed",
             (checks + clkChecks) - (fails + clkFails), checks + clkChecks);
    $finish;
  end

endmodule